// File: doc/BRIEF.md
# Dual-Rate Block Serializer with Per-Phase CRC16

This block turns a stream of bytes into one framed data block on a 4-line or 8-line data bus. In dual-rate mode each bus cycle carries two phase slots. Bytes in odd positions (1st, 3rd, ... 511th, counted from one) go out in the rising-edge slot. Bytes in even positions (2nd, 4th, ... 512th) go out in the falling-edge slot. Every active line keeps two CRC16 accumulators, one for each phase. Both CRCs are sent after the data, each in the slot of its own phase. In single-rate mode only the rising slot carries data, and each line has one CRC.

The output is a pair of per-cycle vectors, `rise_o` and `fall_o`, qualified by `vld_o`. The pad logic and strobe generation of the chip are not part of this block. A cycle with `vld_o` low is a stall cycle, and the bus clock is expected to be held during it. Bytes come in through a ready/valid handshake. Mode and width are sampled when `start_i` is seen while the block is idle. `done_o` marks the end-bit beat.

Top module: `ddr_blk_ser`

## Requirements
- R1: After reset `vld_o`, `done_o` and `byte_ready_o` are 0, and `rise_o` and `fall_o` are 8'hFF.
- R2: On `start_i` while idle, the next beat is a start beat. Active lines are 0 and inactive lines are 1 (8'h00 in 8-line mode, 8'hF0 in 4-line mode), and `fall_o` equals `rise_o`.
- R3: Dual-rate 8-line mode (`ddr_i`=1, `wide_i`=1) sends 256 data beats. Beat p has byte 2p+1 on `rise_o` and byte 2p+2 on `fall_o`, both counted from one, with byte bit i on line i.
- R4: Dual-rate 4-line mode (`wide_i`=0) sends 512 data beats. Each pair of bytes uses two beats, the high nibble first, on lines 3:0. The odd byte is on `rise_o` and the even byte on `fall_o`. Lines 7:4 stay at 1 in every beat of the block.
- R5: Single-rate mode (`ddr_i`=0) sends one byte per beat in 8-line mode, or two beats per byte in 4-line mode (high nibble first). `fall_o` equals `rise_o` in every beat.
- R6: After the data come 16 CRC beats, with bit 15 sent first. The CRC uses polynomial x^16+x^12+x^5+1 and starts from zero for each block. In dual-rate mode, line i of `rise_o` carries the CRC of line i's rising-slot data bits, and line i of `fall_o` carries the CRC of its falling-slot data bits. In single-rate mode there is one CRC per line, and it appears on both outputs. Inactive lines stay at 1.
- R7: The last beat is an end beat with all lines at 1 on both outputs. `done_o` is high in that beat only, and the block then goes idle.
- R8: A byte is taken when `byte_valid_i` and `byte_ready_o` are both high. Exactly 512 bytes are taken per block, and `byte_ready_o` is low when idle and after the 512th byte. When no data is available, no beat is emitted (`vld_o` low) and both outputs hold their values.
- R9: Changes to `ddr_i` and `wide_i` during a block have no effect on that block.
- R10: `start_i` while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block (taken only when idle) |
| ddr_i | input | 1 | 1 = dual-rate, 0 = single-rate; sampled at start |
| wide_i | input | 1 | 1 = 8 lines, 0 = 4 lines; sampled at start |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte available |
| byte_ready_o | output | 1 | Payload byte taken this cycle if valid |
| vld_o | output | 1 | Beat on rise_o/fall_o is valid |
| rise_o | output | 8 | Rising-slot line values |
| fall_o | output | 8 | Falling-slot line values |
| done_o | output | 1 | High during the end-bit beat |

## Verification
Two events can happen on the same clock edge: the data path uses up the buffered pair and emits its beat, and the handshake accepts the first byte of the next pair. This is provoked with an input that is valid on every cycle in dual-rate 8-line mode, where every beat edge also accepts a byte. It is provoked again with a pseudo-random valid pattern, so that the overlap happens at irregular points. A reference model builds the expected beat sequence from the requirements, including both CRC streams of every line. Each valid beat is compared against that sequence, so a byte that is lost or taken twice at the shared edge shows up as a wrong data or CRC beat, or as an unexpected beat.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  localparam int LANES = 8;
  localparam int HALF  = LANES / 2;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_CRC, S_END} st_e;

  function automatic logic [LANES-1:0] nib_pad(logic [HALF-1:0] n);
    return {{HALF{1'b1}}, n};
  endfunction
endpackage

// File: rtl/ddr_ser_gather.sv
module ddr_ser_gather #(
  parameter int BLOCK_BYTES = 512,
  localparam int CW = $clog2(BLOCK_BYTES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       pair_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  input  logic       pop_i,
  output logic       ready_o,
  output logic       full_o,
  output logic [7:0] odd_o,
  output logic [7:0] even_o
);
  logic [1:0]    cnt_q;
  logic [CW-1:0] left_q;
  logic          push;

  assign full_o  = (cnt_q == (pair_i ? 2'd2 : 2'd1));
  // a byte may enter on the edge that frees the buffer
  assign ready_o = (left_q != '0) && (!full_o || pop_i);
  assign push    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      left_q <= '0;
      odd_o  <= '0;
      even_o <= '0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      left_q <= CW'(BLOCK_BYTES);
    end else begin
      if (push) left_q <= left_q - 1'b1;
      if (pop_i && push) begin
        cnt_q <= 2'd1;
        odd_o <= byte_i;
      end else if (pop_i) begin
        cnt_q <= '0;
      end else if (push) begin
        if (cnt_q == '0) odd_o <= byte_i;
        else             even_o <= byte_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_ser_crc_lane.sv
module ddr_ser_crc_lane #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q;

  assign msb_o = crc_q[CRC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (upd_i)   crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ((crc_q[CRC_W-1] ^ bit_i) ? POLY : '0);
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/ddr_blk_ser.sv
module ddr_blk_ser
  import ddr_ser_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ddr_i,
  input  logic             wide_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             vld_o,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o,
  output logic             done_o
);
  localparam int CW = $clog2(BLOCK_BYTES + 1);
  localparam int KW = $clog2(CRC_W);

  st_e           st_q;
  logic          ddr_q, wide_q, nib_q;
  logic [CW-1:0] left_q;
  logic [KW-1:0] crc_cnt_q;

  logic          start_go, beat, pop, shifting, g_full;
  logic [7:0]    g_odd, g_even, f_src;
  logic [CW-1:0] step;
  logic [LANES-1:0] act, start_mask, d_rise, d_fall, c_rise, c_fall, crc_r_msb, crc_f_msb;

  assign start_go   = (st_q == S_IDLE) && start_i;
  assign beat       = (st_q == S_DATA) && g_full;
  assign pop        = beat && (wide_q || nib_q);
  assign shifting   = (st_q == S_CRC);
  assign step       = ddr_q ? CW'(2) : CW'(1);
  assign act        = wide_q ? '1 : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign start_mask = wide_i ? '0 : {{HALF{1'b1}}, {HALF{1'b0}}};
  assign f_src      = ddr_q ? g_even : g_odd;

  always_comb begin
    if (wide_q) begin
      d_rise = g_odd;
      d_fall = f_src;
    end else begin
      d_rise = nib_pad(nib_q ? g_odd[HALF-1:0] : g_odd[LANES-1:HALF]);
      d_fall = nib_pad(nib_q ? f_src[HALF-1:0] : f_src[LANES-1:HALF]);
    end
  end

  assign c_rise = crc_r_msb | ~act;
  assign c_fall = ddr_q ? (crc_f_msb | ~act) : c_rise;

  ddr_ser_gather #(.BLOCK_BYTES(BLOCK_BYTES)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (start_go),
    .pair_i  (ddr_q),
    .byte_i  (byte_i),
    .valid_i (byte_valid_i),
    .pop_i   (pop),
    .ready_o (byte_ready_o),
    .full_o  (g_full),
    .odd_o   (g_odd),
    .even_o  (g_even)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ddr_ser_crc_lane #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_rise (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start_go),
      .upd_i   (beat),
      .shift_i (shifting),
      .bit_i   (d_rise[i]),
      .msb_o   (crc_r_msb[i])
    );
    ddr_ser_crc_lane #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_fall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start_go),
      .upd_i   (beat && ddr_q),
      .shift_i (shifting),
      .bit_i   (d_fall[i]),
      .msb_o   (crc_f_msb[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ddr_q     <= 1'b0;
      wide_q    <= 1'b0;
      nib_q     <= 1'b0;
      left_q    <= '0;
      crc_cnt_q <= '0;
      rise_o    <= '1;
      fall_o    <= '1;
      vld_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          rise_o <= '1;
          fall_o <= '1;
          if (start_i) begin
            ddr_q  <= ddr_i;
            wide_q <= wide_i;
            nib_q  <= 1'b0;
            left_q <= CW'(BLOCK_BYTES);
            rise_o <= start_mask;
            fall_o <= start_mask;
            vld_o  <= 1'b1;
            st_q   <= S_DATA;
          end
        end
        S_DATA: begin
          if (g_full) begin
            rise_o <= d_rise;
            fall_o <= d_fall;
            vld_o  <= 1'b1;
            if (!wide_q) nib_q <= ~nib_q;
            if (pop) begin
              left_q <= left_q - step;
              if (left_q == step) begin
                crc_cnt_q <= '0;
                st_q      <= S_CRC;
              end
            end
          end
        end
        S_CRC: begin
          rise_o    <= c_rise;
          fall_o    <= c_fall;
          vld_o     <= 1'b1;
          crc_cnt_q <= crc_cnt_q + 1'b1;
          if (crc_cnt_q == KW'(CRC_W - 1)) st_q <= S_END;
        end
        S_END: begin
          rise_o <= '1;
          fall_o <= '1;
          vld_o  <= 1'b1;
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_blk_ser_chk.sv
module ddr_blk_ser_chk
  import ddr_ser_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  localparam int CW = $clog2(BLOCK_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             byte_valid_i,
  input logic             byte_ready_i,
  input logic             vld_i,
  input logic [LANES-1:0] rise_i,
  input logic [LANES-1:0] fall_i,
  input logic             done_i,
  input logic             ddr_q_i,
  input logic             wide_q_i,
  input st_e              st_i
);
  logic [CW:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          acc_q <= '0;
    else if (st_i == S_IDLE && start_i)   acc_q <= '0;
    else if (byte_valid_i && byte_ready_i) acc_q <= acc_q + 1'b1;
  end

  a_r2_start_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_i == S_IDLE && start_i) |->
      vld_i && rise_i == (wide_q_i ? 8'h00 : 8'hF0) && fall_i == rise_i);

  a_r4_upper_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !wide_q_i |-> rise_i[7:4] == 4'hF && fall_i[7:4] == 4'hF);

  a_r5_sdr_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !ddr_q_i |-> fall_i == rise_i);

  a_r7_done_is_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> vld_i && rise_i == 8'hFF && fall_i == 8'hFF);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> $stable(rise_i) && $stable(fall_i));

  a_r8_ready_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_i |-> st_i == S_DATA);

  a_r8_accept_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= (CW+1)'(BLOCK_BYTES));
endmodule

bind ddr_blk_ser ddr_blk_ser_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .byte_ready_i (byte_ready_o),
  .vld_i        (vld_o),
  .rise_i       (rise_o),
  .fall_i       (fall_o),
  .done_i       (done_o),
  .ddr_q_i      (ddr_q),
  .wide_q_i     (wide_q),
  .st_i         (st_q)
);

// File: tb/ddr_blk_ser_test.sv
`timescale 1ns/1ps
module ddr_blk_ser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, ddr_i = 1'b0, wide_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_ready_o, vld_o, done_o;
  logic [7:0] rise_o, fall_o;

  int  checks = 0, errors = 0, cycles = 0;
  bit  fin = 1'b0;

  logic [7:0] q_rise[$];
  logic [7:0] q_fall[$];
  bit         q_done[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  ddr_blk_ser uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .ddr_i(ddr_i), .wide_i(wide_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .vld_o(vld_o), .rise_o(rise_o), .fall_o(fall_o), .done_o(done_o)
  );

  function automatic logic [7:0] blk_byte(int seed, int k);
    return 8'((k * 7 + seed * 29 + (k / 5)) & 255);
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic push_beat(logic [7:0] r, logic [7:0] f, bit d, string t);
    q_rise.push_back(r);
    q_fall.push_back(f);
    q_done.push_back(d);
    q_tag.push_back(t);
  endtask

  task automatic build(bit ddr, bit wide, int seed, string dtag);
    logic [7:0]  dr[$];
    logic [7:0]  df[$];
    logic [15:0] cr[8];
    logic [15:0] cf[8];
    logic [7:0]  pad, o, e, rr, ff;
    pad = wide ? 8'h00 : 8'hF0;
    push_beat(pad, pad, 1'b0, "R2");
    if (ddr) begin
      for (int p = 0; p < 256; p++) begin
        o = blk_byte(seed, 2 * p);
        e = blk_byte(seed, 2 * p + 1);
        if (wide) begin
          dr.push_back(o); df.push_back(e);
        end else begin
          dr.push_back({4'hF, o[7:4]}); df.push_back({4'hF, e[7:4]});
          dr.push_back({4'hF, o[3:0]}); df.push_back({4'hF, e[3:0]});
        end
      end
    end else begin
      for (int k = 0; k < 512; k++) begin
        o = blk_byte(seed, k);
        if (wide) begin
          dr.push_back(o); df.push_back(o);
        end else begin
          dr.push_back({4'hF, o[7:4]}); df.push_back({4'hF, o[7:4]});
          dr.push_back({4'hF, o[3:0]}); df.push_back({4'hF, o[3:0]});
        end
      end
    end
    foreach (dr[j]) push_beat(dr[j], df[j], 1'b0, dtag);
    for (int i = 0; i < 8; i++) begin
      cr[i] = '0;
      cf[i] = '0;
      foreach (dr[j]) begin
        cr[i] = crc_step(cr[i], dr[j][i]);
        cf[i] = crc_step(cf[i], df[j][i]);
      end
    end
    for (int b = 15; b >= 0; b--) begin
      rr = pad;
      ff = pad;
      for (int i = 0; i < 8; i++) begin
        rr[i] = rr[i] | cr[i][b];
        ff[i] = ff[i] | cf[i][b];
      end
      if (!ddr) ff = rr;
      push_beat(rr, ff, 1'b0, "R6");
    end
    push_beat(8'hFF, 8'hFF, 1'b1, "R7");
  endtask

  // R8: payload handshake; R9/R10 poke changes mode inputs and pulses start mid-block
  task automatic run(bit ddr, bit wide, int seed, bit gaps, bit poke, string dtag);
    int          k;
    logic [15:0] lf;
    k  = 0;
    lf = 16'hACE1 ^ 16'(seed);
    build(ddr, wide, seed, dtag);
    @(negedge clk);
    ddr_i = ddr; wide_i = wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (k < 512) begin
      bit v;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v  = gaps ? (lf[0] | lf[3]) : 1'b1;
      byte_valid_i = v;
      byte_i = blk_byte(seed, k);
      if (poke && k == 100) begin
        start_i = 1'b1; ddr_i = ~ddr; wide_i = ~wide;
      end else begin
        start_i = 1'b0;
      end
      if (v && byte_ready_o) k++;
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    start_i = 1'b0;
    while (q_rise.size() != 0) begin
      chk(byte_ready_o == 1'b0, "R8", "ready after 512 bytes", 16'(byte_ready_o), 16'd0);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(vld_o == 1'b0, "R7", "idle after end beat", 16'(vld_o), 16'd0);
    chk(byte_ready_o == 1'b0, "R8", "ready when idle", 16'(byte_ready_o), 16'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (vld_o) begin
        if (q_rise.size() == 0) begin
          chk(1'b0, "R8", "unexpected beat", 16'(rise_o), 16'd0);
        end else begin
          logic [7:0] r, f;
          bit d;
          string t;
          r = q_rise.pop_front();
          f = q_fall.pop_front();
          d = q_done.pop_front();
          t = q_tag.pop_front();
          chk(rise_o == r, t, "rise_o", 16'(rise_o), 16'(r));
          chk(fall_o == f, t, "fall_o", 16'(fall_o), 16'(f));
          chk(done_o == d, t, "done_o", 16'(done_o), 16'(d));
        end
      end else begin
        chk(done_o == 1'b0, "R7", "done without beat", 16'(done_o), 16'd0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !fin) begin
      fin = 1'b1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired: actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(vld_o == 1'b0,        "R1", "vld_o",        16'(vld_o), 16'd0);
    chk(done_o == 1'b0,       "R1", "done_o",       16'(done_o), 16'd0);
    chk(byte_ready_o == 1'b0, "R1", "byte_ready_o", 16'(byte_ready_o), 16'd0);
    chk(rise_o == 8'hFF,      "R1", "rise_o",       16'(rise_o), 16'h00FF);
    chk(fall_o == 8'hFF,      "R1", "fall_o",       16'(fall_o), 16'h00FF);

    run(1'b1, 1'b1, 1, 1'b0, 1'b0, "R3");
    run(1'b1, 1'b0, 2, 1'b0, 1'b0, "R4");
    run(1'b0, 1'b1, 3, 1'b0, 1'b0, "R5");
    run(1'b0, 1'b0, 4, 1'b0, 1'b0, "R5");
    run(1'b1, 1'b1, 5, 1'b1, 1'b0, "R8");
    run(1'b1, 1'b0, 6, 1'b1, 1'b1, "R9 R10");
    run(1'b0, 1'b1, 7, 1'b1, 1'b1, "R9 R10");

    repeat (5) @(negedge clk);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule